// File: doc/BRIEF.md
# Dual-Enable Asynchronous SRAM Port

This block is a byte-wide static memory placed behind a classic asynchronous bus. The bus has an address, an active-low enable, an active-high enable, an active-low output enable and an active-low write enable. A fast system clock oversamples every control pin. The block works out the bus mode from the sampled pins. It requests ownership of the data lines only while a read is in progress. It writes a byte when a write window closes.

Inside the chip the bidirectional data bus is split into three signals: an input byte, an output byte and an output-enable. The pad ring combines them into the physical tri-state pin. A power-fail deselect input overrides everything else. While it is high the port is in standby, whatever the bus pins show.

The depth is set by `ADDR_W`. The product instance uses `ADDR_W = 13`, giving 8192 bytes. The default of 10 keeps the elaborated array small.

Top module: `dual_enable_sram_port`

## Requirements
- R1: When `ce_n_i` is 1 or `ce_i` is 0, the port is in standby and `dq_oe_o` is 0, whatever `oe_n_i` and `we_n_i` show.
- R2: With `ce_n_i`=0, `ce_i`=1, `we_n_i`=1 and `oe_n_i`=0, `dq_oe_o` is 1 and `dq_o` carries the byte stored at `addr_i`.
- R3: With both enables asserted and `we_n_i`=1, `oe_n_i`=1 keeps `dq_oe_o` at 0.
- R4: While both enables are asserted and `we_n_i`=0, `dq_oe_o` is 0, even when `oe_n_i` is 0.
- R5: A write window opens at the last of three events: `we_n_i` falling, `ce_n_i` falling, or `ce_i` rising. It closes at the first of the matching deasserting edges. Any of the three may open it and any of them may close it.
- R6: When a read is driving and `we_n_i` falls, `dq_oe_o` drops. When an enable asserts in the same cycle as `we_n_i` goes low, `dq_oe_o` never rises.
- R7: A 1 on `pfd_i` holds `dq_oe_o` at 0, whatever the other controls show.
- R8: A 1 on `pfd_i` blocks every commit, including a window already open when it rises; the addressed byte keeps its old value.
- R9: Each control input passes through a two-flop synchronizer. A control change is visible on `dq_oe_o` after the second rising clock edge that follows it. A closed window's byte is stored by the third rising edge after the close.
- R10: Every one of the 2^ADDR_W addresses holds its own byte, written and read back independently.
- R11: After reset, `dq_oe_o` is 0 and no write is pending.
- R12: The byte stored is the value on `dq_i`, at the address on `addr_i`, in the cycle the window is seen to close.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pfd_i | input | 1 | Power-fail deselect; 1 forces standby |
| ce_n_i | input | 1 | Active-low chip enable |
| ce_i | input | 1 | Active-high chip enable |
| oe_n_i | input | 1 | Active-low output enable |
| we_n_i | input | 1 | Active-low write enable |
| addr_i | input | ADDR_W | Byte address (13 in the full configuration) |
| dq_i | input | DATA_W | Data bus as seen from the pad, used for writes |
| dq_o | output | DATA_W | Read byte toward the pad (0 when not driving) |
| dq_oe_o | output | 1 | Pad drive enable for the data bus |

## Verification
The assertions take for granted that `addr_i` stays constant for as long as the synchronized write window stays open. The bench therefore sets the address before the first control edge of a write. It keeps the address and data unchanged for three clock cycles after the closing edge, then moves them. The bench also keeps `oe_n_i` high during its bulk writes and never drives `dq_i` toward a port that is reading, so bus ownership is never contested.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;

  typedef enum logic [2:0] {
    MODE_STANDBY,
    MODE_IDLE,
    MODE_READ,
    MODE_WRITE,
    MODE_FAIL
  } bus_mode_e;

  typedef struct packed {
    logic pfd;
    logic ce_n;
    logic ce;
    logic oe_n;
    logic we_n;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // Value every synchronizer stage takes in reset: deselected, power failed.
  localparam logic [CTRL_W-1:0] CTRL_SAFE = 5'b1_1_0_1_1;

  function automatic bus_mode_e decode_mode(input ctrl_t c);
    if (c.pfd)                   return MODE_FAIL;
    else if (c.ce_n || !c.ce)    return MODE_STANDBY;
    else if (!c.we_n)            return MODE_WRITE;
    else if (!c.oe_n)            return MODE_READ;
    else                         return MODE_IDLE;
  endfunction

endpackage

// File: rtl/sram_sync_bank.sv
module sram_sync_bank #(
  parameter int              W       = 5,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  localparam int LAST = STAGES - 1;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else        chain <= {chain[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain[LAST];
  end

endmodule

// File: rtl/sram_write_window.sv
module sram_write_window
  import sram_port_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  bus_mode_e mode,
  output logic      win_act,
  output logic      commit
);

  logic win_q;

  assign win_act = (mode == MODE_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= 1'b0;
    else        win_q <= win_act;
  end

  // Close seen this cycle; a failing supply cancels the commit.
  assign commit = win_q && !win_act && (mode != MODE_FAIL);

endmodule

// File: rtl/sram_byte_array.sv
module sram_byte_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/dual_enable_sram_port.sv
module dual_enable_sram_port
  import sram_port_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pfd_i,
  input  logic              ce_n_i,
  input  logic              ce_i,
  input  logic              oe_n_i,
  input  logic              we_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);

  ctrl_t             ctrl_raw;
  ctrl_t             ctrl_s;
  logic [CTRL_W-1:0] sync_vec;
  bus_mode_e         mode;
  logic              win_act;
  logic              commit;
  logic              pfd_s;
  logic              standby_s;
  logic [DATA_W-1:0] rd_byte;

  assign ctrl_raw = '{pfd: pfd_i, ce_n: ce_n_i, ce: ce_i, oe_n: oe_n_i, we_n: we_n_i};

  sram_sync_bank #(
    .W      (CTRL_W),
    .STAGES (2),
    .RST_VAL(CTRL_SAFE)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(ctrl_raw),
    .sync_o (sync_vec)
  );

  assign ctrl_s    = ctrl_t'(sync_vec);
  assign mode      = decode_mode(ctrl_s);
  assign pfd_s     = (mode == MODE_FAIL);
  assign standby_s = (mode == MODE_STANDBY);

  sram_write_window u_window (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (mode),
    .win_act(win_act),
    .commit (commit)
  );

  sram_byte_array #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_array (
    .clk    (clk),
    .wr_en  (commit),
    .wr_addr(addr_i),
    .wr_data(dq_i),
    .rd_addr(addr_i),
    .rd_data(rd_byte)
  );

  assign dq_oe_o = (mode == MODE_READ);
  assign dq_o    = dq_oe_o ? rd_byte : '0;

endmodule

// File: rtl/dual_enable_sram_port_chk.sv
module dual_enable_sram_port_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              pfd_s,
  input logic              standby_s,
  input logic              win_act,
  input logic              commit,
  input logic              drive_en
);

  AST_STANDBY_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    standby_s |-> !drive_en) else $error("standby drives bus"); // R1

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    win_act |-> !drive_en) else $error("write window drives bus"); // R4

  AST_FAIL_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    pfd_s |-> !drive_en) else $error("power fail drives bus"); // R7

  AST_FAIL_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    pfd_s |-> !commit) else $error("power fail commits"); // R8

  AST_COMMIT_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (!win_act && $past(win_act))) else $error("commit without close"); // R5

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (win_act && $past(win_act)) |-> $stable(addr_i)) else $error("address moved in window"); // R12

endmodule

bind dual_enable_sram_port dual_enable_sram_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr_i   (addr_i),
  .pfd_s    (pfd_s),
  .standby_s(standby_s),
  .win_act  (win_act),
  .commit   (commit),
  .drive_en (dq_oe_o)
);

// File: tb/dual_enable_sram_port_bench.sv
module dual_enable_sram_port_bench;

  localparam int ADDR_W = 10;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              pfd = 1'b0;
  logic              ce_n = 1'b1;
  logic              ce = 1'b0;
  logic              oe_n = 1'b1;
  logic              we_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] din = '0;
  logic [DATA_W-1:0] dout;
  logic              doe;

  logic [DATA_W-1:0] model [DEPTH];
  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  dual_enable_sram_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dual_enable_sram_port (
    .clk(clk), .rst_n(rst_n), .pfd_i(pfd), .ce_n_i(ce_n), .ce_i(ce),
    .oe_n_i(oe_n), .we_n_i(we_n), .addr_i(addr), .dq_i(din),
    .dq_o(dout), .dq_oe_o(doe)
  );

  function automatic logic [DATA_W-1:0] pat(input int a);
    return 8'(((a * 37) + (a >> 3)) ^ 8'h5A);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // 0: write enable, 1: active-low enable, 2: active-high enable
  task automatic set_sig(input int k, input bit on);
    case (k)
      0: we_n = !on;
      1: ce_n = !on;
      default: ce = on;
    endcase
  endtask

  task automatic idle_bus();
    ce_n = 1'b1; ce = 1'b0; oe_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic do_write(input int a, input logic [DATA_W-1:0] d, input int open_k,
                          input int close_k, input bit oe_low);
    addr = ADDR_W'(a); din = d; oe_n = !oe_low;
    for (int j = 0; j < 3; j++) if (j != open_k) set_sig(j, 1'b1);
    tick(1);
    set_sig(open_k, 1'b1);
    tick(3);
    // R4: no drive inside the window
    check(doe == 1'b0, "R4", {8'h0, doe}, 9'h0);
    set_sig(close_k, 1'b0);
    tick(3);
    idle_bus();
    model[a] = d;
    tick(1);
  endtask

  task automatic read_check(input int a, input string req);
    addr = ADDR_W'(a);
    ce_n = 1'b0; ce = 1'b1; we_n = 1'b1; oe_n = 1'b0;
    tick(2);
    check(doe == 1'b1 && dout == model[a], req, {doe, dout}, {1'b1, model[a]});
    idle_bus();
    tick(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick(1);
    check(doe == 1'b0, "R11", {8'h0, doe}, 9'h0);
    tick(3);

    // R10 R5 R12: every address, all open/close edge pairings
    for (int a = 0; a < DEPTH; a++)
      do_write(a, pat(a), a % 3, (a / 3) % 3, 1'b0);
    for (int a = 0; a < DEPTH; a++) read_check(a, "R10");

    // R1 R2 R3 R4 R7: sweep every control combination
    for (int c = 0; c < 32; c++) begin
      bit p, cn, cp, on, wn, exp_drv, is_wr;
      p = c[4]; cn = c[3]; cp = c[2]; on = c[1]; wn = c[0];
      addr = 10'd5; din = 8'hC3 ^ 8'(c);
      pfd = p; ce_n = cn; ce = cp; oe_n = on; we_n = wn;
      tick(2);
      exp_drv = !p && !cn && cp && wn && !on;
      is_wr   = !p && !cn && cp && !wn;
      check(doe == exp_drv && (!exp_drv || dout == model[5]),
            p ? "R7" : ((cn || !cp) ? "R1" : (!wn ? "R4" : (on ? "R3" : "R2"))),
            {doe, dout}, {exp_drv, exp_drv ? model[5] : 8'h0});
      pfd = 1'b0; idle_bus();
      if (is_wr) model[5] = din;
      tick(3);
      read_check(5, "R12");
    end

    // R8: power fail during an open window cancels the commit
    addr = 10'd7; din = 8'hEE; ce_n = 1'b0; ce = 1'b1; we_n = 1'b0;
    tick(3);
    pfd = 1'b1;
    tick(3);
    idle_bus();
    tick(2);
    pfd = 1'b0;
    tick(3);
    read_check(7, "R8");

    // R8: power fail held over a whole window, no write
    pfd = 1'b1; addr = 10'd8; din = 8'h11;
    ce_n = 1'b0; ce = 1'b1; we_n = 1'b0;
    tick(3);
    idle_bus();
    tick(3);
    pfd = 1'b0;
    tick(3);
    read_check(8, "R8");

    // R6: enable and write enable asserted in the same cycle, oe low
    addr = 10'd9; din = 8'h3C; ce = 1'b1; oe_n = 1'b0; ce_n = 1'b1; we_n = 1'b1;
    tick(3);
    ce_n = 1'b0; we_n = 1'b0;
    for (int i = 0; i < 5; i++) begin
      tick(1);
      check(doe == 1'b0, "R6", {8'h0, doe}, 9'h0);
    end
    idle_bus(); model[9] = 8'h3C;
    tick(4);
    read_check(9, "R6");

    // R6 R9: drive turns off after we falls, new byte appears after close
    addr = 10'd10; ce_n = 1'b0; ce = 1'b1; oe_n = 1'b0; we_n = 1'b1;
    tick(2);
    check(doe == 1'b1 && dout == model[10], "R9", {doe, dout}, {1'b1, model[10]});
    we_n = 1'b0;
    tick(2);
    check(doe == 1'b0, "R6", {8'h0, doe}, 9'h0);
    din = 8'hA5;
    tick(1);
    we_n = 1'b1; model[10] = 8'hA5;
    tick(3);
    check(doe == 1'b1 && dout == 8'hA5, "R9", {doe, dout}, 9'h1A5);
    idle_bus();
    tick(2);

    // R4: write with output enable held low
    do_write(11, 8'h96, 2, 1, 1'b1);
    read_check(11, "R4");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule